// File: doc/BRIEF.md
# Bulk Transfer Response Deframer

This block sits behind the receive FIFO of a bulk register-transfer engine and turns the 32-bit words of one reply packet back into the bytes the requester needs. It handles one outstanding command at a time. A command-tracking port supplies the expected packet identifier, the command kind (write or read) and, for reads, the number of data bytes to expect. The block then consumes the reply words, drops the padding the peripheral inserted, and presents the header response, the footer response and, for reads, the data check byte together with a one-cycle completion pulse. Read data leaves as a byte stream with a valid/ready handshake.

Each received word keeps its payload in bits 15..0. Bit 31 flags the first word of a packet, bit 30 the last one, and bits 19..16 hold the packet identifier. A reply whose markers do not fit the expected length is reported as a framing fault. The rest of that packet is thrown away up to its end-marked word, and the block returns to wait for the next command. An identifier that differs from the expected one is reported separately, and the reply is still processed.

Top module: `bulk_resp_deframer`

## Requirements
- R1: After reset, cmd_ready is 1, in_ready is 0, dat_valid is 0, done is 0, and both error flags are 0.
- R2: A write reply is two words. The header response is bits 7..0 of the word with bit 31 set. The footer response is bits 7..0 of the following word with bit 30 set. Bits 15..8 of both words are ignored. For a write, crc_byte reads 0.
- R3: A read reply carries data after its header word, two bytes per word. Bits 7..0 leave before bits 15..8. When the length is odd, the final word holds one byte in bits 7..0, and its bits 15..8 are dropped. dat_last is 1 exactly on the final data byte.
- R4: In a read reply, the data check byte is bits 7..0 of the word after the data, and the footer response is bits 7..0 of the next word, which has bit 30 set. Bits 15..8 of both words are ignored.
- R5: A read of length 0 has a header word, a check-byte word and a footer word. It emits no data bytes.
- R6: done is high for exactly one cycle, the cycle after the footer word is accepted. During that cycle hdr_rsp, ftr_rsp and crc_byte hold the values of that reply. A faulty reply raises no done.
- R7: While a data byte is offered and not taken, that byte stays stable, and no further reply word is accepted, so no byte is lost when dat_ready is low.
- R8: If bits 19..16 of a start-marked word differ from the expected identifier, err_id sets and stays set until reset. The reply still completes normally.
- R9: If the first reply word lacks bit 31, err_frame sets and stays set until reset. Words are discarded up to and including the next word with bit 30 set.
- R10: A word with bit 30 set that arrives before the expected footer position sets err_frame and ends the packet. Data bytes already taken from earlier words of that packet remain emitted.
- R11: If the expected footer word lacks bit 30, err_frame sets, and words are discarded up to and including the next word with bit 30 set.
- R12: Only one command is outstanding. After a command is accepted, cmd_ready stays low until the reply completes or its fault handling ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Expected-reply descriptor offered |
| cmd_ready | output | 1 | Descriptor accepted when high with cmd_valid |
| cmd_is_read | input | 1 | 1 for a read reply, 0 for a write reply |
| cmd_id | input | 4 | Expected packet identifier |
| cmd_len | input | 10 | Expected read data length in bytes |
| in_valid | input | 1 | Receive FIFO word available |
| in_ready | output | 1 | Word consumed when high with in_valid |
| in_word | input | 32 | Receive FIFO word |
| dat_valid | output | 1 | Read data byte offered |
| dat_ready | input | 1 | Downstream takes the byte |
| dat_byte | output | 8 | Read data byte |
| dat_last | output | 1 | Final data byte of the reply |
| done | output | 1 | One-cycle completion pulse |
| hdr_rsp | output | 8 | Header response of the completed reply |
| ftr_rsp | output | 8 | Footer response of the completed reply |
| crc_byte | output | 8 | Data check byte of the completed read reply |
| err_frame | output | 1 | Sticky framing fault flag |
| err_id | output | 1 | Sticky identifier mismatch flag |

## Verification
The hardest case to reach is recovery after a fault in the middle of a reply. The block must first emit the bytes it already unpacked. It must then discard exactly the words up to the end marker and pick up the next command's reply cleanly. The stimulus puts an early end marker in the second data word of a read, a stray single-word reply, a header without a start marker, and a footer without an end marker. Each is followed at once by a well-formed reply whose bytes and completion pulse are compared. Output stalls and gaps in FIFO delivery run together, so the back-pressure path is exercised in the middle of odd-length and even-length reads.

// File: rtl/bulk_resp_pkg.sv
package bulk_resp_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int ID_W    = 4;
    localparam int LEN_W   = 10;
    localparam int SOP_POS = 31;
    localparam int EOP_POS = 30;
    localparam int ID_LSB  = 16;
    localparam int PAIR_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        PH_IDLE, PH_HDR, PH_DATA, PH_CRC, PH_FTR, PH_DRAIN
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic                rd;
        logic [ID_W-1:0]     id;
        logic [LEN_W-1:0]    rem;
        logic [PAIR_W-1:0]   hold;
        logic [1:0]          hcnt;
        logic [BYTE_W-1:0]   hdr;
        logic [BYTE_W-1:0]   ftr;
        logic [BYTE_W-1:0]   crc;
        logic                done;
    } ctx_t;

    localparam ctx_t CTX_RST = '{ph: PH_IDLE, default: '0};
endpackage

// File: rtl/bulk_resp_fields.sv
module bulk_resp_fields import bulk_resp_pkg::*; (
    input  logic [WORD_W-1:0] word,
    output logic              sop,
    output logic              eop,
    output logic [ID_W-1:0]   id,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi
);
    assign sop = word[SOP_POS];
    assign eop = word[EOP_POS];
    assign id  = word[ID_LSB +: ID_W];
    assign lo  = word[0 +: BYTE_W];
    assign hi  = word[BYTE_W +: BYTE_W];
endmodule

// File: rtl/bulk_resp_sticky.sv
module bulk_resp_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb flag_d = flag_q | set;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/bulk_resp_deframer.sv
module bulk_resp_deframer import bulk_resp_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_is_read,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic [BYTE_W-1:0] dat_byte,
    output logic              dat_last,
    output logic              done,
    output logic [BYTE_W-1:0] hdr_rsp,
    output logic [BYTE_W-1:0] ftr_rsp,
    output logic [BYTE_W-1:0] crc_byte,
    output logic              err_frame,
    output logic              err_id
);
    ctx_t c_d, c_q;

    logic              w_sop, w_eop;
    logic [ID_W-1:0]   w_id;
    logic [BYTE_W-1:0] w_lo, w_hi;
    logic              fault_d, idbad_d;

    bulk_resp_fields u_fields (
        .word (in_word),
        .sop  (w_sop),
        .eop  (w_eop),
        .id   (w_id),
        .lo   (w_lo),
        .hi   (w_hi)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        fault_d   = 1'b0;
        idbad_d   = 1'b0;
        in_ready  = 1'b0;
        cmd_ready = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    c_d.ph   = PH_HDR;
                    c_d.rd   = cmd_is_read;
                    c_d.id   = cmd_id;
                    c_d.rem  = cmd_is_read ? cmd_len : '0;
                    c_d.hcnt = '0;
                    c_d.hdr  = '0;
                    c_d.ftr  = '0;
                    c_d.crc  = '0;
                end
            end
            PH_HDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (w_sop && (w_id != c_q.id)) idbad_d = 1'b1;
                    if (!w_sop || w_eop) begin
                        fault_d = 1'b1;
                    end else begin
                        c_d.hdr = w_lo;
                        if (!c_q.rd)                c_d.ph = PH_FTR;
                        else if (c_q.rem == '0)     c_d.ph = PH_CRC;
                        else                        c_d.ph = PH_DATA;
                    end
                end
            end
            PH_DATA: begin
                if (c_q.hcnt == 2'd0) begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        if (w_sop || w_eop) begin
                            fault_d = 1'b1;
                        end else begin
                            c_d.hold = {w_hi, w_lo};
                            if (c_q.rem >= LEN_W'(2)) begin
                                c_d.hcnt = 2'd2;
                                c_d.rem  = c_q.rem - LEN_W'(2);
                            end else begin
                                c_d.hcnt = 2'd1;
                                c_d.rem  = c_q.rem - LEN_W'(1);
                            end
                        end
                    end
                end else if (dat_ready) begin
                    c_d.hold = c_q.hold >> BYTE_W;
                    c_d.hcnt = c_q.hcnt - 2'd1;
                    if (c_q.hcnt == 2'd1 && c_q.rem == '0) c_d.ph = PH_CRC;
                end
            end
            PH_CRC: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (w_sop || w_eop) begin
                        fault_d = 1'b1;
                    end else begin
                        c_d.crc = w_lo;
                        c_d.ph  = PH_FTR;
                    end
                end
            end
            PH_FTR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (w_sop || !w_eop) begin
                        fault_d = 1'b1;
                    end else begin
                        c_d.ftr  = w_lo;
                        c_d.done = 1'b1;
                        c_d.ph   = PH_IDLE;
                    end
                end
            end
            PH_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && w_eop) c_d.ph = PH_IDLE;
            end
            default: c_d.ph = PH_IDLE;
        endcase
        if (fault_d) begin
            c_d.hcnt = '0;
            c_d.ph   = w_eop ? PH_IDLE : PH_DRAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CTX_RST;
        else        c_q <= c_d;
    end

    bulk_resp_sticky u_frame_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fault_d),
        .flag  (err_frame)
    );

    bulk_resp_sticky u_id_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (idbad_d),
        .flag  (err_id)
    );

    assign dat_valid = (c_q.ph == PH_DATA) && (c_q.hcnt != 2'd0);
    assign dat_byte  = c_q.hold[BYTE_W-1:0];
    assign dat_last  = dat_valid && (c_q.hcnt == 2'd1) && (c_q.rem == '0);
    assign done      = c_q.done;
    assign hdr_rsp   = c_q.hdr;
    assign ftr_rsp   = c_q.ftr;
    assign crc_byte  = c_q.crc;
endmodule

// File: rtl/bulk_resp_deframer_chk.sv
module bulk_resp_deframer_chk import bulk_resp_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              dat_valid,
    input logic              dat_ready,
    input logic [BYTE_W-1:0] dat_byte,
    input logic              done,
    input logic              err_frame,
    input logic              err_id
);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_byte)));

    assert_id_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_id |=> err_id);

    assert_frame_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> err_frame);

    assert_one_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind bulk_resp_deframer bulk_resp_deframer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dat_valid (dat_valid),
    .dat_ready (dat_ready),
    .dat_byte  (dat_byte),
    .done      (done),
    .err_frame (err_frame),
    .err_id    (err_id)
);

// File: tb/bulk_resp_deframer_test.sv
module bulk_resp_deframer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_is_read = 1'b0;
    logic [3:0] cmd_id = '0;
    logic [9:0] cmd_len = '0;
    logic       cmd_ready;
    logic       in_valid = 1'b0, in_ready;
    logic [31:0] in_word = '0;
    logic       dat_valid, dat_ready = 1'b1, dat_last, done, err_frame, err_id;
    logic [7:0] dat_byte, hdr_rsp, ftr_rsp, crc_byte;

    always #10 clk = ~clk;

    bulk_resp_deframer uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_read(cmd_is_read),
        .cmd_id(cmd_id), .cmd_len(cmd_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte), .dat_last(dat_last),
        .done(done), .hdr_rsp(hdr_rsp), .ftr_rsp(ftr_rsp), .crc_byte(crc_byte),
        .err_frame(err_frame), .err_id(err_id)
    );

    logic [31:0] wq[$];
    logic [14:0] cq[$];
    logic [8:0]  eb[$];
    logic [23:0] ed[$];
    int total = 0, bad = 0, cyc = 0;
    bit stall_on = 0, gap_on = 0, in_fire = 0, cmd_fire = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(bit s, bit e, logic [3:0] id, logic [7:0] hi, logic [7:0] lo);
        return {s, e, 10'd0, id, hi, lo};
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (in_fire)  void'(wq.pop_front());
        if (cmd_fire) void'(cq.pop_front());
        in_valid  = (wq.size() > 0) && !(gap_on && (cyc % 4 == 1));
        in_word   = in_valid ? wq[0] : 32'hDEAD_BEEF;
        cmd_valid = cq.size() > 0;
        {cmd_is_read, cmd_id, cmd_len} = cmd_valid ? cq[0] : 15'd0;
        dat_ready = !(stall_on && (cyc % 3 == 0));
        #1;
        in_fire  = in_valid && in_ready;
        cmd_fire = cmd_valid && cmd_ready;
        if (rst_n) begin
            if (dat_valid) chk("R7", {31'd0, in_ready}, 32'd0, "word accepted while byte pending");
            if (dat_valid && dat_ready) begin
                if (eb.size() == 0) chk("R3", {23'd0, dat_last, dat_byte}, 32'h1FF, "unexpected data byte");
                else chk("R3", {23'd0, dat_last, dat_byte}, {23'd0, eb.pop_front()}, "data byte/last");
            end
            if (done) begin
                if (ed.size() == 0) chk("R6", 32'd1, 32'd0, "unexpected done (R9 R10 R11 faults give none)");
                else chk("R6", {8'd0, hdr_rsp, ftr_rsp, crc_byte}, {8'd0, ed.pop_front()}, "hdr/ftr/crc at done");
            end
        end
        if (cyc > 100000) begin
            bad++;
            $display("FAIL R6 watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_write(logic [3:0] cid, logic [3:0] rid, logic [7:0] h, logic [7:0] f);
        cq.push_back({1'b0, cid, 10'd0});
        wq.push_back(mkw(1, 0, rid, 8'hE7, h));
        wq.push_back(mkw(0, 1, 4'd0, 8'h18, f));
        ed.push_back({h, f, 8'h00});
    endtask

    task automatic do_read(logic [3:0] cid, logic [3:0] rid, int len, logic [7:0] base,
                           logic [7:0] h, logic [7:0] c, logic [7:0] f);
        cq.push_back({1'b1, cid, 10'(len)});
        wq.push_back(mkw(1, 0, rid, 8'hC3, h));
        for (int i = 0; i < len; i += 2) begin
            if (i + 1 < len) begin
                wq.push_back(mkw(0, 0, 4'd0, 8'(base + i + 1), 8'(base + i)));
                eb.push_back({1'b0, 8'(base + i)});
                eb.push_back({(i + 1 == len - 1), 8'(base + i + 1)});
            end else begin
                wq.push_back(mkw(0, 0, 4'd0, 8'h3C, 8'(base + i)));
                eb.push_back({1'b1, 8'(base + i)});
            end
        end
        wq.push_back(mkw(0, 0, 4'd0, 8'h99, c));
        wq.push_back(mkw(0, 1, 4'd0, 8'h66, f));
        ed.push_back({h, f, c});
    endtask

    task automatic quiet(string req);
        while (wq.size() > 0 || cq.size() > 0) @(negedge clk);
        repeat (20) @(negedge clk);
        #2;
        chk(req, eb.size(), 0, "data bytes still expected");
        chk(req, ed.size(), 0, "done pulses still expected");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", {31'd0, cmd_ready}, 32'd1, "cmd_ready after reset");
        chk("R1", {31'd0, in_ready}, 32'd0, "in_ready after reset");
        chk("R1", {31'd0, dat_valid}, 32'd0, "dat_valid after reset");
        chk("R1", {31'd0, done}, 32'd0, "done after reset");
        chk("R1", {30'd0, err_frame, err_id}, 32'd0, "flags after reset");

        // R2 R3 R4 R5 R12: well-formed traffic, first free-flowing
        do_write(4'd0, 4'd0, 8'h11, 8'h22);
        do_read(4'd1, 4'd1, 4, 8'h40, 8'h33, 8'h44, 8'h55);
        do_read(4'd2, 4'd2, 5, 8'h50, 8'h66, 8'h77, 8'h88);
        do_read(4'd3, 4'd3, 0, 8'h00, 8'h9A, 8'hAB, 8'hBC);
        quiet("R2");
        // R7: output stalls and input gaps together
        stall_on = 1; gap_on = 1;
        do_read(4'd4, 4'd4, 7, 8'h70, 8'h01, 8'h02, 8'h03);
        do_write(4'd5, 4'd5, 8'h04, 8'h05);
        do_read(4'd6, 4'd6, 1, 8'hA0, 8'h06, 8'h07, 8'h08);
        do_read(4'd7, 4'd7, 6, 8'hB0, 8'h09, 8'h0A, 8'h0B);
        quiet("R7");
        chk("R9", {31'd0, err_frame}, 32'd0, "no framing fault on good traffic");
        chk("R8", {31'd0, err_id}, 32'd0, "no id fault on good traffic");

        // R8: id mismatch, reply still completes
        do_read(4'd4, 4'd7, 3, 8'hC0, 8'h1A, 8'h2B, 8'h3C);
        quiet("R8");
        chk("R8", {31'd0, err_id}, 32'd1, "err_id after mismatch");
        chk("R8", {31'd0, err_frame}, 32'd0, "no framing fault on mismatch");
        do_write(4'd8, 4'd8, 8'h4D, 8'h5E);
        quiet("R8");
        chk("R8", {31'd0, err_id}, 32'd1, "err_id stays set");
        do_reset();
        #2;
        chk("R1", {30'd0, err_frame, err_id}, 32'd0, "flags cleared by reset");

        // R9: first word without start marker, drained to end marker
        cq.push_back({1'b0, 4'd1, 10'd0});
        wq.push_back(mkw(0, 0, 4'd1, 8'hFF, 8'hEE));
        wq.push_back(mkw(1, 0, 4'd1, 8'hDD, 8'hCC));
        wq.push_back(mkw(0, 1, 4'd1, 8'hBB, 8'hAA));
        do_write(4'd2, 4'd2, 8'h61, 8'h62);
        quiet("R9");
        chk("R9", {31'd0, err_frame}, 32'd1, "err_frame after missing start");
        do_reset();

        // R10: early end marker in second data word, then single-word write reply
        cq.push_back({1'b1, 4'd3, 10'd4});
        wq.push_back(mkw(1, 0, 4'd3, 8'h00, 8'h71));
        wq.push_back(mkw(0, 0, 4'd0, 8'hD1, 8'hD0));
        eb.push_back({1'b0, 8'hD0});
        eb.push_back({1'b0, 8'hD1});
        wq.push_back(mkw(0, 1, 4'd0, 8'hD3, 8'hD2));
        cq.push_back({1'b0, 4'd4, 10'd0});
        wq.push_back(mkw(1, 1, 4'd4, 8'h00, 8'h72));
        do_read(4'd5, 4'd5, 2, 8'hE0, 8'h73, 8'h74, 8'h75);
        quiet("R10");
        chk("R10", {31'd0, err_frame}, 32'd1, "err_frame after early end");
        chk("R10", {31'd0, err_id}, 32'd0, "no id fault on early end");
        do_reset();

        // R11: footer without end marker, drained through stray end word
        stall_on = 0;
        cq.push_back({1'b0, 4'd6, 10'd0});
        wq.push_back(mkw(1, 0, 4'd6, 8'h00, 8'h81));
        wq.push_back(mkw(0, 0, 4'd0, 8'h00, 8'h82));
        wq.push_back(mkw(0, 0, 4'd0, 8'h00, 8'h83));
        wq.push_back(mkw(0, 1, 4'd0, 8'h00, 8'h84));
        do_read(4'd9, 4'd9, 3, 8'hF0, 8'h85, 8'h86, 8'h87);
        quiet("R11");
        chk("R11", {31'd0, err_frame}, 32'd1, "err_frame after missing end");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule